// File: doc/BRIEF.md
# Remote Operand Buffer with Sticky Stack-Pointer Entries

This block sits in one cluster of a clustered out-of-order core. It keeps local copies of source operands that a different cluster produces, so a local consumer does not pay the extra cycle of a remote register-file access on every use. Each buffer entry is reserved by an allocation request that carries a physical register tag and a flag that marks a stack-pointer producer. The entry then waits until the producing cluster broadcasts the result on the capture port. After that, local consumers can read it.

The entries are split into two pools. The ordinary pool serves one-shot operands: one consumer read empties the entry. The reserved pool holds stack-pointer values, and it behaves differently. A stack-pointer entry stays readable for any number of reads. It is only released when a newer stack-pointer producer commits. A flush input drops everything that has not committed.

There are two handshakes. Allocation uses valid/ready: a request is taken on a cycle where `alloc_valid` and `alloc_ready` are both high. While `alloc_ready` is low the requester must hold its request, and low ready is the stall indication. `alloc_ready` depends on `alloc_sp` and on `flush`, but never on `alloc_valid`. A read also uses valid/ready: `rd_ready` reports a hit for `rd_tag` in the same cycle, and a read is consumed on a cycle where `rd_valid` and `rd_ready` are both high. Result capture is a broadcast with no back-pressure. Commit and flush are plain strobes. Tags of live entries are assumed unique, which the rename logic guarantees.

Top module: `remote_operand_buf`

## Requirements
- R1: After reset every entry is empty. `alloc_ready` is 1 for both values of `alloc_sp`, and `rd_ready` is 0 for any tag.
- R2: An ordinary allocation (`alloc_sp`=0) is accepted while one of the `NORM_N` ordinary entries is free. When all of them are occupied, `alloc_ready` is 0 for `alloc_sp`=0 until one frees.
- R3: An allocated entry gives `rd_ready`=0 for its tag until a result with that tag is captured. From the cycle after the capture, a read of that tag gives `rd_ready`=1 and `rd_data` equal to the captured word.
- R4: When a capture and a read name the same allocated, still-waiting tag in one cycle, the read hits in that cycle, and `rd_data` is the incoming word.
- R5: A consumed read of an ordinary entry frees it at that clock edge. In the next cycle that tag misses, and the slot can be allocated again.
- R6: Stack-pointer allocations use only the `SP_N` reserved entries. A full ordinary pool does not lower `alloc_ready` for `alloc_sp`=1.
- R7: A stack-pointer entry holding data stays readable with unchanged data across any number of consumed reads.
- R8: A stack-pointer commit with tag T marks T's entry committed and releases every other committed stack-pointer entry at that edge. While all reserved entries are occupied, `alloc_ready` is 0 for `alloc_sp`=1, and it returns to 1 after such a release.
- R9: During a `flush` cycle `alloc_ready` is 0. The flush empties all ordinary entries and all uncommitted stack-pointer entries, and keeps committed stack-pointer entries with their data.
- R10: A capture is taken only by an entry that is allocated and still waiting. A capture for an unallocated tag creates nothing, and a second capture for an entry that already holds data leaves its data unchanged.
- R11: A read of a tag held by no entry gives `rd_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request present |
| alloc_ready | output | 1 | Allocation can be taken this cycle (low = stall) |
| alloc_tag | input | TAG_W | Physical register tag to reserve |
| alloc_sp | input | 1 | Request is for a stack-pointer producer |
| res_valid | input | 1 | Result broadcast present |
| res_tag | input | TAG_W | Tag of the broadcast result |
| res_data | input | DATA_W | Broadcast result word |
| rd_valid | input | 1 | Local consumer read present |
| rd_ready | output | 1 | `rd_tag` hits with data available |
| rd_tag | input | TAG_W | Tag being read |
| rd_data | output | DATA_W | Operand for `rd_tag` |
| sp_commit_valid | input | 1 | A stack-pointer producer commits |
| sp_commit_tag | input | TAG_W | Tag of the committing stack-pointer producer |
| flush | input | 1 | Discard all uncommitted entries |

## Verification
An internal fault shows up at the ports within one cycle. An entry lost too early gives a read miss in the cycle after the wrong edge. An entry freed too late keeps hitting after its single use, or holds `alloc_ready` low one cycle too long. A wrong release of a stack-pointer entry appears as a miss on the next read of its tag. Missed captures or forwarding appear as `rd_ready` staying low or `rd_data` carrying the wrong word in the very cycle of the read. The directed tasks probe each of these cycles: right after a consume, a commit, a flush, or a capture.

// File: rtl/rop_pkg.sv
package rop_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_FULL = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rop_entry.sv
module rop_entry
  import rop_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_take,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              alloc_sp,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  input  logic              rd_take,
  input  logic              cmt_valid,
  input  logic [TAG_W-1:0]  cmt_tag,
  input  logic              flush,
  output logic              e_busy,
  output logic              e_full,
  output logic              e_sp,
  output logic [TAG_W-1:0]  e_tag,
  output logic [DATA_W-1:0] e_data
);
  slot_state_e       st_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q;
  logic              sp_q;
  logic              cmt_q;
  logic              cap_hit;
  logic              cmt_self;
  logic              cmt_other;

  always_comb begin
    cap_hit   = (st_q == SLOT_WAIT) && res_valid && (res_tag == tag_q);
    cmt_self  = (st_q != SLOT_FREE) && sp_q && cmt_valid && (cmt_tag == tag_q);
    cmt_other = (st_q != SLOT_FREE) && sp_q && cmt_q && cmt_valid && (cmt_tag != tag_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SLOT_FREE;
      tag_q  <= '0;
      data_q <= '0;
      sp_q   <= 1'b0;
      cmt_q  <= 1'b0;
    end else if (alloc_take) begin
      st_q  <= SLOT_WAIT;
      tag_q <= alloc_tag;
      sp_q  <= alloc_sp;
      cmt_q <= 1'b0;
    end else begin
      if (cap_hit) begin
        st_q   <= SLOT_FULL;
        data_q <= res_data;
      end
      if (cmt_self) cmt_q <= 1'b1;
      if (rd_take && !sp_q) st_q <= SLOT_FREE;
      if (cmt_other) st_q <= SLOT_FREE;
      if (flush && !(cmt_q || cmt_self)) st_q <= SLOT_FREE;
    end
  end

  assign e_busy = (st_q != SLOT_FREE);
  assign e_full = (st_q == SLOT_FULL);
  assign e_sp   = sp_q;
  assign e_tag  = tag_q;
  assign e_data = data_q;

  // R2
  alloc_on_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_take |-> (st_q == SLOT_FREE));

  // R7
  sp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SLOT_FULL) && sp_q && !flush && !cmt_valid && !alloc_take)
      |=> (st_q == SLOT_FULL));

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SLOT_FULL) && !alloc_take) |=> (data_q == $past(data_q)));

  // R5
  single_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !sp_q) |=> (st_q == SLOT_FREE));
endmodule

// File: rtl/rop_pick.sv
module rop_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] free_vec,
  output logic [N-1:0] grant,
  output logic         any_free
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_vec[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign any_free = |free_vec;
endmodule

// File: rtl/rop_lookup.sv
module rop_lookup #(
  parameter int E      = 6,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic [E-1:0]             busy,
  input  logic [E-1:0]             full,
  input  logic [E-1:0]             sp,
  input  logic [E-1:0][TAG_W-1:0]  tags,
  input  logic [E-1:0][DATA_W-1:0] datas,
  input  logic [TAG_W-1:0]         rd_tag,
  input  logic                     res_valid,
  input  logic [TAG_W-1:0]         res_tag,
  input  logic [DATA_W-1:0]        res_data,
  output logic [E-1:0]             match,
  output logic                     hit,
  output logic                     hit_sp,
  output logic [DATA_W-1:0]        data
);
  logic              fwd;
  logic              sel_full;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    fwd      = res_valid && (res_tag == rd_tag);
    sel_full = 1'b0;
    sel_data = '0;
    hit_sp   = 1'b0;
    for (int i = 0; i < E; i++) begin
      match[i] = busy[i] && (tags[i] == rd_tag);
      if (match[i]) begin
        sel_full = sel_full | full[i];
        sel_data = sel_data | datas[i];
        hit_sp   = hit_sp | sp[i];
      end
    end
    hit  = (|match) && (sel_full || fwd);
    data = sel_full ? sel_data : res_data;
  end
endmodule

// File: rtl/remote_operand_buf.sv
module remote_operand_buf #(
  parameter int NORM_N = 4,
  parameter int SP_N   = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              alloc_sp,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sp_commit_valid,
  input  logic [TAG_W-1:0]  sp_commit_tag,
  input  logic              flush
);
  localparam int E = NORM_N + SP_N;

  logic [E-1:0]             ent_busy;
  logic [E-1:0]             ent_full;
  logic [E-1:0]             ent_sp;
  logic [E-1:0][TAG_W-1:0]  ent_tag;
  logic [E-1:0][DATA_W-1:0] ent_data;
  logic [E-1:0]             ent_take;
  logic [E-1:0]             rd_match;
  logic [NORM_N-1:0]        gnt_n;
  logic [SP_N-1:0]          gnt_s;
  logic                     any_n;
  logic                     any_s;
  logic                     alloc_fire;
  logic                     rd_fire;
  logic                     rd_hit;
  logic                     rd_hit_sp;

  rop_pick #(.N(NORM_N)) u_pick_norm (
    .free_vec (~ent_busy[NORM_N-1:0]),
    .grant    (gnt_n),
    .any_free (any_n)
  );

  rop_pick #(.N(SP_N)) u_pick_sp (
    .free_vec (~ent_busy[E-1:NORM_N]),
    .grant    (gnt_s),
    .any_free (any_s)
  );

  assign alloc_ready = !flush && (alloc_sp ? any_s : any_n);
  assign alloc_fire  = alloc_valid && alloc_ready;

  rop_lookup #(.E(E), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lookup (
    .busy      (ent_busy),
    .full      (ent_full),
    .sp        (ent_sp),
    .tags      (ent_tag),
    .datas     (ent_data),
    .rd_tag    (rd_tag),
    .res_valid (res_valid),
    .res_tag   (res_tag),
    .res_data  (res_data),
    .match     (rd_match),
    .hit       (rd_hit),
    .hit_sp    (rd_hit_sp),
    .data      (rd_data)
  );

  assign rd_ready = rd_hit;
  assign rd_fire  = rd_valid && rd_hit;

  for (genvar g = 0; g < E; g++) begin : g_slot
    if (g < NORM_N) begin : g_norm
      assign ent_take[g] = alloc_fire && !alloc_sp && gnt_n[g];
    end else begin : g_sp
      assign ent_take[g] = alloc_fire && alloc_sp && gnt_s[g-NORM_N];
    end

    rop_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_take (ent_take[g]),
      .alloc_tag  (alloc_tag),
      .alloc_sp   (alloc_sp),
      .res_valid  (res_valid),
      .res_tag    (res_tag),
      .res_data   (res_data),
      .rd_take    (rd_fire && rd_match[g]),
      .cmt_valid  (sp_commit_valid),
      .cmt_tag    (sp_commit_tag),
      .flush      (flush),
      .e_busy     (ent_busy[g]),
      .e_full     (ent_full[g]),
      .e_sp       (ent_sp[g]),
      .e_tag      (ent_tag[g]),
      .e_data     (ent_data[g])
    );
  end

  // R5
  consumed_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !rd_hit_sp && !(alloc_fire && alloc_tag == rd_tag))
      |=> !(rd_ready && rd_tag == $past(rd_tag)));

  // R9
  flush_leaves_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rd_ready || rd_hit_sp));
endmodule

// File: tb/test_remote_operand_buf.sv
module test_remote_operand_buf;
  localparam int TAG_W  = 6;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc_valid = 1'b0;
  logic              alloc_ready;
  logic [TAG_W-1:0]  alloc_tag = '0;
  logic              alloc_sp = 1'b0;
  logic              res_valid = 1'b0;
  logic [TAG_W-1:0]  res_tag = '0;
  logic [DATA_W-1:0] res_data = '0;
  logic              rd_valid = 1'b0;
  logic              rd_ready;
  logic [TAG_W-1:0]  rd_tag = '0;
  logic [DATA_W-1:0] rd_data;
  logic              sp_commit_valid = 1'b0;
  logic [TAG_W-1:0]  sp_commit_tag = '0;
  logic              flush = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  remote_operand_buf #(.NORM_N(4), .SP_N(2), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_remote_operand_buf (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag), .alloc_sp(alloc_sp),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_tag(rd_tag), .rd_data(rd_data),
    .sp_commit_valid(sp_commit_valid), .sp_commit_tag(sp_commit_tag), .flush(flush)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic idle;
    alloc_valid = 1'b0; res_valid = 1'b0; rd_valid = 1'b0;
    sp_commit_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic do_reset;
    idle();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic alloc(input logic [TAG_W-1:0] t, input logic sp, input string req);
    alloc_valid = 1'b1; alloc_tag = t; alloc_sp = sp;
    #1 chk(req, "alloc_ready on allocate", alloc_ready, 1);
    tick(); idle();
  endtask

  task automatic probe_alloc(input logic sp, input logic exp, input string req);
    alloc_valid = 1'b1; alloc_tag = 6'd63; alloc_sp = sp;
    #1 chk(req, "alloc_ready probe", alloc_ready, exp);
    alloc_valid = 1'b0;
    #1;
  endtask

  task automatic capture(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
    res_valid = 1'b1; res_tag = t; res_data = d;
    tick(); idle();
  endtask

  task automatic commit(input logic [TAG_W-1:0] t);
    sp_commit_valid = 1'b1; sp_commit_tag = t;
    tick(); idle();
  endtask

  task automatic read(input logic [TAG_W-1:0] t, input logic exp_hit, input logic [DATA_W-1:0] exp_d, input string req);
    rd_valid = 1'b1; rd_tag = t;
    #1 chk(req, "rd_ready", rd_ready, exp_hit);
    if (exp_hit) chk(req, "rd_data", rd_data, exp_d);
    tick(); idle();
  endtask

  task automatic t_reset;
    do_reset();
    probe_alloc(1'b0, 1'b1, "R1");
    probe_alloc(1'b1, 1'b1, "R1");
    read(6'd5, 1'b0, '0, "R1");
    read(6'd17, 1'b0, '0, "R11");
  endtask

  task automatic t_ordinary;
    do_reset();
    for (int i = 1; i <= 4; i++) alloc(TAG_W'(i), 1'b0, "R2");
    probe_alloc(1'b0, 1'b0, "R2");
    probe_alloc(1'b1, 1'b1, "R6");
    read(6'd1, 1'b0, '0, "R3");
    capture(6'd1, 16'hA1A1);
    read(6'd1, 1'b1, 16'hA1A1, "R3");
    read(6'd1, 1'b0, '0, "R5");
    probe_alloc(1'b0, 1'b1, "R5");
    res_valid = 1'b1; res_tag = 6'd2; res_data = 16'hB2B2;
    read(6'd2, 1'b1, 16'hB2B2, "R4");
    capture(6'd3, 16'hC3C3);
    capture(6'd3, 16'hDDDD);
    capture(6'd40, 16'h4040);
    read(6'd40, 1'b0, '0, "R10");
    read(6'd3, 1'b1, 16'hC3C3, "R10");
  endtask

  task automatic t_sticky;
    do_reset();
    alloc(6'd10, 1'b1, "R6");
    capture(6'd10, 16'h1010);
    for (int i = 0; i < 3; i++) read(6'd10, 1'b1, 16'h1010, "R7");
    commit(6'd10);
    alloc(6'd11, 1'b1, "R8");
    probe_alloc(1'b1, 1'b0, "R8");
    capture(6'd11, 16'h1111);
    read(6'd10, 1'b1, 16'h1010, "R7");
    commit(6'd11);
    read(6'd10, 1'b0, '0, "R8");
    probe_alloc(1'b1, 1'b1, "R8");
    read(6'd11, 1'b1, 16'h1111, "R8");
  endtask

  task automatic t_flush;
    do_reset();
    alloc(6'd20, 1'b1, "R9");
    capture(6'd20, 16'h2020);
    commit(6'd20);
    alloc(6'd21, 1'b1, "R9");
    alloc(6'd22, 1'b0, "R9");
    capture(6'd22, 16'h2222);
    flush = 1'b1; alloc_valid = 1'b1; alloc_tag = 6'd23; alloc_sp = 1'b0;
    #1 chk("R9", "alloc_ready during flush", alloc_ready, 0);
    tick(); idle();
    read(6'd20, 1'b1, 16'h2020, "R9");
    read(6'd22, 1'b0, '0, "R9");
    capture(6'd21, 16'h2121);
    read(6'd21, 1'b0, '0, "R9");
    capture(6'd23, 16'h2323);
    read(6'd23, 1'b0, '0, "R9");
    probe_alloc(1'b1, 1'b1, "R9");
  endtask

  initial begin
    t_reset();
    t_ordinary();
    t_sticky();
    t_flush();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule